// File: doc/BRIEF.md
# Address-Remapping Unit Control Registers

This block is the register file that software uses to steer a DMA address-remapping unit. Software reaches it through a simple single-cycle write port and a combinational read port, both addressed by byte offset. It holds read-only identification and capability words. It accepts one-shot commands through a write-only command word and reports their effect in a separate status word. It keeps the pending root-table address, and it runs context-cache and IOTLB invalidation handshakes whose request bit reads back as 1 until the work is done.

Every timed operation (write-buffer flush, context invalidation, IOTLB invalidation) lasts `OP_LAT` cycles. A second request of the same kind that arrives while one is running is held and starts in the cycle the first one completes. The end of each invalidation drives a one-cycle pulse to the lookup logic, with the scope fields captured when that operation started. The IOTLB invalidation word sits at the byte offset that the extended capability advertises: its field in bits 17:8, times 16, plus 8.

Top module: `remap_ctl_regs`

## Requirements
- R1: After reset, the status word at offset 0x20 reads 0, `trans_en` is 0, `root_ptr` is 0 and no pulse is driven. Offsets 0x00, 0x08 and 0x10 read the version, capability and extended-capability parameters.
- R2: Every write to the command word (offset 0x18) sets `trans_en` and status bit 31 to the written bit 31, from the next cycle on. Writing 0 turns translation off.
- R3: A command write with bit 30 set copies the root-table address word (offset 0x28) to `root_ptr` and sets status bit 30. A later write of offset 0x28 clears status bit 30 and leaves `root_ptr` unchanged.
- R4: A command write with bit 27 set starts a flush. Status bit 27 reads 1 for exactly `OP_LAT` cycles after the write, then reads 0.
- R5: A write of the context command word (offset 0x30) with bit 63 set makes bit 63 read 1 for `OP_LAT` cycles. `ctx_inv_pulse` is high for one cycle, in the last of those cycles, and `ctx_inv_global` then carries written bit 61.
- R6: The IOTLB word, at byte offset (ecap[17:8]*16)+8, takes bit 63 as its request, with the same timing as R5, and drives `iotlb_inv_pulse`. At that pulse, `iotlb_inv_gran` is written bits 61:60 and `iotlb_drain_rd` and `iotlb_drain_wr` are bits 49 and 48. `iotlb_inv_did` is bits 47:32 masked to the domain count that capability bits 2:0 give (code n gives 16·4^n domains). The other written bits read back unchanged.
- R7: A request written while the same operation is pending is held and runs once the first completes. Two pulses result, and the request bit stays 1 without a gap until the second completes. This includes a request written in the very cycle the first completes.
- R8: Command bits other than 31, 30 and 27 have no effect. The command word reads 0, and unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| trans_en | output | 1 | Translation enabled |
| root_ptr | output | 64 | Active root-table pointer |
| ctx_inv_pulse | output | 1 | Context cache invalidate pulse |
| ctx_inv_global | output | 1 | Global scope for the context pulse |
| iotlb_inv_pulse | output | 1 | IOTLB invalidate pulse |
| iotlb_inv_gran | output | 2 | IOTLB granularity (1 global, 2 domain, 3 page) |
| iotlb_inv_did | output | 16 | Domain ID for the IOTLB pulse |
| iotlb_drain_rd | output | 1 | Drain pending reads before invalidating |
| iotlb_drain_wr | output | 1 | Drain pending writes before invalidating |

## Verification
The case that matters most is a new IOTLB request written in the same cycle that the previous one completes. The completion pulse and the launch of the second operation then share one clock. The bench provokes this by timing the second write `OP_LAT` cycles after the first. It judges the result by three things: exactly two pulses appear, the request bit holds 1 for the full second window, and the last pulse carries the second write's granularity and domain. A queued context request written one cycle after the first is checked the same way, for an unbroken pending window of 2·`OP_LAT`−1 sampled cycles.

// File: rtl/remap_regs_pkg.sv
package remap_regs_pkg;
  // byte offsets of the fixed registers
  localparam int A_VER  = 'h00;
  localparam int A_CAP  = 'h08;
  localparam int A_ECAP = 'h10;
  localparam int A_GCMD = 'h18;
  localparam int A_GSTS = 'h20;
  localparam int A_RTA  = 'h28;
  localparam int A_CCMD = 'h30;

  // command / status bit positions
  localparam int B_TE   = 31;
  localparam int B_SRTP = 30;
  localparam int B_WBF  = 27;
  localparam int B_REQ  = 63;
  localparam int B_CGLB = 61;

  // timed operation slots
  localparam int OP_WBF = 0;
  localparam int OP_CTX = 1;
  localparam int OP_IOT = 2;
  localparam int N_OPS  = 3;

  // domain-id mask for a domain count code (16 * 4^code domains)
  function automatic logic [15:0] dom_mask(input logic [2:0] code);
    logic [31:0] n;
    if (code > 3'd6) return 16'hFFFF;
    n = (32'd16 << (2 * code)) - 32'd1;
    return n[15:0];
  endfunction

  // IOTLB register byte offset advertised by the extended capability
  function automatic int iotlb_off(input logic [63:0] ecap);
    return int'(ecap[17:8]) * 16 + 8;
  endfunction
endpackage

// File: rtl/remap_op_timer.sv
module remap_op_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pending,
  output logic done,
  output logic launch
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT);

  logic          busy_q, queued_q;
  logic [CW-1:0] cnt_q;

  assign done    = busy_q && (cnt_q == '0);
  assign launch  = (start && !busy_q) || (done && (queued_q || start));
  assign pending = busy_q | queued_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      queued_q <= 1'b0;
      cnt_q    <= '0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      cnt_q    <= CW'(LAT - 1);
      queued_q <= done && queued_q && start;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (start) queued_q <= 1'b1;
    end
  end

  p_queue_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    queued_q |-> busy_q);
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) < LAT));
  p_start_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pending);
endmodule

// File: rtl/remap_glob_ctl.sv
module remap_glob_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gcmd_wr,
  input  logic        cmd_te,
  input  logic        cmd_srtp,
  input  logic        rta_wr,
  input  logic [63:0] rta_wdata,
  output logic        te_q,
  output logic        rtps_q,
  output logic [63:0] rta_q,
  output logic [63:0] root_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      te_q   <= 1'b0;
      rtps_q <= 1'b0;
      rta_q  <= '0;
      root_q <= '0;
    end else begin
      if (gcmd_wr) te_q <= cmd_te;
      if (gcmd_wr && cmd_srtp) begin
        root_q <= rta_q;
        rtps_q <= 1'b1;
      end else if (rta_wr) begin
        rtps_q <= 1'b0;
      end
      if (rta_wr) rta_q <= rta_wdata;
    end
  end

  p_te_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gcmd_wr |=> (te_q == $past(cmd_te)));
  p_root_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gcmd_wr && cmd_srtp) |=> (rtps_q && root_q == $past(rta_q)));
  p_rtps_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rta_wr && !gcmd_wr) |=> (!rtps_q && $stable(root_q)));
endmodule

// File: rtl/remap_ctl_regs.sv
module remap_ctl_regs
  import remap_regs_pkg::*;
#(
  parameter int          ADDR_W   = 14,
  parameter int          OP_LAT   = 4,
  parameter logic [63:0] VER_VAL  = 64'h0000_0000_0000_0010,
  parameter logic [63:0] CAP_VAL  = 64'h0000_0000_0000_0412,
  parameter logic [63:0] ECAP_VAL = 64'h0000_0000_0000_0405
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              trans_en,
  output logic [63:0]       root_ptr,
  output logic              ctx_inv_pulse,
  output logic              ctx_inv_global,
  output logic              iotlb_inv_pulse,
  output logic [1:0]        iotlb_inv_gran,
  output logic [15:0]       iotlb_inv_did,
  output logic              iotlb_drain_rd,
  output logic              iotlb_drain_wr
);
  localparam logic [ADDR_W-1:0] AD_VER  = ADDR_W'(A_VER);
  localparam logic [ADDR_W-1:0] AD_CAP  = ADDR_W'(A_CAP);
  localparam logic [ADDR_W-1:0] AD_ECAP = ADDR_W'(A_ECAP);
  localparam logic [ADDR_W-1:0] AD_GCMD = ADDR_W'(A_GCMD);
  localparam logic [ADDR_W-1:0] AD_GSTS = ADDR_W'(A_GSTS);
  localparam logic [ADDR_W-1:0] AD_RTA  = ADDR_W'(A_RTA);
  localparam logic [ADDR_W-1:0] AD_CCMD = ADDR_W'(A_CCMD);
  localparam logic [ADDR_W-1:0] AD_IOT  = ADDR_W'(iotlb_off(ECAP_VAL));
  localparam logic [15:0]       DID_MASK = dom_mask(CAP_VAL[2:0]);

  // decoded write events, named for the checks
  logic wr_gcmd, wr_rta, wr_ccmd, wr_iot;
  assign wr_gcmd = reg_wr && (reg_addr == AD_GCMD);
  assign wr_rta  = reg_wr && (reg_addr == AD_RTA);
  assign wr_ccmd = reg_wr && (reg_addr == AD_CCMD);
  assign wr_iot  = reg_wr && (reg_addr == AD_IOT);

  logic        te_q, rtps_q;
  logic [63:0] rta_q;

  remap_glob_ctl u_glob (
    .clk       (clk),
    .rst_n     (rst_n),
    .gcmd_wr   (wr_gcmd),
    .cmd_te    (reg_wdata[B_TE]),
    .cmd_srtp  (reg_wdata[B_SRTP]),
    .rta_wr    (wr_rta),
    .rta_wdata (reg_wdata),
    .te_q      (te_q),
    .rtps_q    (rtps_q),
    .rta_q     (rta_q),
    .root_q    (root_ptr)
  );
  assign trans_en = te_q;

  // timed operations
  logic [N_OPS-1:0] op_start, op_pend, op_done, op_launch;
  assign op_start[OP_WBF] = wr_gcmd && reg_wdata[B_WBF];
  assign op_start[OP_CTX] = wr_ccmd && reg_wdata[B_REQ];
  assign op_start[OP_IOT] = wr_iot  && reg_wdata[B_REQ];

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    remap_op_timer #(.LAT(OP_LAT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (op_start[g]),
      .pending (op_pend[g]),
      .done    (op_done[g]),
      .launch  (op_launch[g])
    );
  end

  // stored invalidation words (request bit comes from the timers)
  logic [62:0] ccmd_q, iot_q;
  logic [62:0] ccmd_src, iot_src;
  assign ccmd_src = wr_ccmd ? reg_wdata[62:0] : ccmd_q;
  assign iot_src  = wr_iot  ? reg_wdata[62:0] : iot_q;

  logic        cglb_q, drd_q, dwr_q;
  logic [1:0]  gran_q;
  logic [15:0] did_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccmd_q <= '0;
      iot_q  <= '0;
      cglb_q <= 1'b0;
      gran_q <= '0;
      did_q  <= '0;
      drd_q  <= 1'b0;
      dwr_q  <= 1'b0;
    end else begin
      if (wr_ccmd) ccmd_q <= reg_wdata[62:0];
      if (wr_iot)  iot_q  <= reg_wdata[62:0];
      if (op_launch[OP_CTX]) cglb_q <= ccmd_src[B_CGLB];
      if (op_launch[OP_IOT]) begin
        gran_q <= iot_src[61:60];
        drd_q  <= iot_src[49];
        dwr_q  <= iot_src[48];
        did_q  <= iot_src[47:32] & DID_MASK;
      end
    end
  end

  assign ctx_inv_pulse   = op_done[OP_CTX];
  assign ctx_inv_global  = cglb_q;
  assign iotlb_inv_pulse = op_done[OP_IOT];
  assign iotlb_inv_gran  = gran_q;
  assign iotlb_inv_did   = did_q;
  assign iotlb_drain_rd  = drd_q;
  assign iotlb_drain_wr  = dwr_q;

  // read path
  logic [63:0] gsts;
  always_comb begin
    gsts         = '0;
    gsts[B_TE]   = te_q;
    gsts[B_SRTP] = rtps_q;
    gsts[B_WBF]  = op_pend[OP_WBF];
  end

  always_comb begin
    if      (reg_addr == AD_IOT)  reg_rdata = {op_pend[OP_IOT], iot_q};
    else if (reg_addr == AD_VER)  reg_rdata = VER_VAL;
    else if (reg_addr == AD_CAP)  reg_rdata = CAP_VAL;
    else if (reg_addr == AD_ECAP) reg_rdata = ECAP_VAL;
    else if (reg_addr == AD_GSTS) reg_rdata = gsts;
    else if (reg_addr == AD_RTA)  reg_rdata = rta_q;
    else if (reg_addr == AD_CCMD) reg_rdata = {op_pend[OP_CTX], ccmd_q};
    else                          reg_rdata = '0;
  end

  p_wbf_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start[OP_WBF] |=> op_pend[OP_WBF]);
  p_ctx_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_start[OP_CTX] |=> op_pend[OP_CTX]);
  p_iot_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start[OP_IOT] |=> op_pend[OP_IOT]);
  p_did_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iotlb_inv_pulse |-> ((iotlb_inv_did & ~DID_MASK) == 16'h0));
  p_pulse_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_inv_pulse |-> op_pend[OP_CTX]);
endmodule

// File: tb/remap_ctl_regs_tb.sv
module remap_ctl_regs_tb;
  localparam int          LAT   = 4;
  localparam logic [63:0] VER   = 64'h0000_0000_0000_0010;
  localparam logic [63:0] CAP   = 64'h0000_0000_0000_0412; // code 2: 256 domains
  localparam logic [63:0] ECAP  = 64'h0000_0000_0000_0405; // IRO field = 4
  localparam logic [13:0] A_IOT = 14'h48;                  // 4*16+8
  localparam logic [13:0] A_GCMD = 14'h18, A_GSTS = 14'h20, A_RTA = 14'h28, A_CCMD = 14'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata, root_ptr;
  logic        trans_en, ctx_inv_pulse, ctx_inv_global, iotlb_inv_pulse;
  logic [1:0]  iotlb_inv_gran;
  logic [15:0] iotlb_inv_did;
  logic        iotlb_drain_rd, iotlb_drain_wr;

  always #4 clk = ~clk;

  remap_ctl_regs #(.ADDR_W(14), .OP_LAT(LAT), .VER_VAL(VER), .CAP_VAL(CAP), .ECAP_VAL(ECAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trans_en(trans_en), .root_ptr(root_ptr),
    .ctx_inv_pulse(ctx_inv_pulse), .ctx_inv_global(ctx_inv_global),
    .iotlb_inv_pulse(iotlb_inv_pulse), .iotlb_inv_gran(iotlb_inv_gran),
    .iotlb_inv_did(iotlb_inv_did), .iotlb_drain_rd(iotlb_drain_rd),
    .iotlb_drain_wr(iotlb_drain_wr));

  int total = 0, bad = 0;
  int n_ctx = 0, n_iot = 0;
  logic last_glb = 1'b0, last_drd = 1'b0, last_dwr = 1'b0;
  logic [1:0]  last_gran = '0;
  logic [15:0] last_did = '0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (ctx_inv_pulse) begin n_ctx++; last_glb = ctx_inv_global; end
    if (iotlb_inv_pulse) begin
      n_iot++; last_gran = iotlb_inv_gran; last_did = iotlb_inv_did;
      last_drd = iotlb_drain_rd; last_dwr = iotlb_drain_wr;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic count_ones(input logic [13:0] a, input int bitn, input int span, output int ones);
    logic [63:0] v;
    ones = 0;
    for (int k = 0; k < span; k++) begin
      rd(a, v);
      if (v[bitn]) ones++;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [13:0] waddr;
    logic [63:0] wdata;
    logic [13:0] raddr;
    logic [63:0] rexp;
    logic [63:0] rootexp;
    logic        teexp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{14'h28, 64'h1234_5000, 14'h28, 64'h1234_5000, 64'h0, 1'b0},          // R3 store address
    '{14'h18, 64'h4000_0000, 14'h20, 64'h4000_0000, 64'h1234_5000, 1'b0},  // R3 latch
    '{14'h18, 64'hC000_0000, 14'h20, 64'hC000_0000, 64'h1234_5000, 1'b1},  // R2 enable
    '{14'h28, 64'hABCD_0000, 14'h20, 64'h8000_0000, 64'h1234_5000, 1'b1},  // R3 status clears
    '{14'h18, 64'h0,         14'h20, 64'h0,         64'h1234_5000, 1'b0},  // R2 disable
    '{14'h18, 64'h37FF_FFFF, 14'h20, 64'h0,         64'h1234_5000, 1'b0},  // R8 other bits
    '{14'h100, 64'hFFFF_FFFF_FFFF_FFFF, 14'h100, 64'h0, 64'h1234_5000, 1'b0}, // R8 unmapped
    '{14'h18, 64'h8000_0000, 14'h18, 64'h0,         64'h1234_5000, 1'b1}   // R8 cmd reads 0
  };

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int ones, c0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_GSTS, v);  chk("R1 status", v, 64'h0);
    rd(14'h00, v);  chk("R1 version", v, VER);
    rd(14'h08, v);  chk("R1 cap", v, CAP);
    rd(14'h10, v);  chk("R1 ecap", v, ECAP);
    chk("R1 trans_en", {63'h0, trans_en}, 64'h0);
    chk("R1 root_ptr", root_ptr, 64'h0);
    chk("R1 pulses", 64'(n_ctx + n_iot), 64'h0);
    @(negedge clk);

    // register vectors
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, v);
      chk("R2/R3/R8 vector read", v, VECS[i].rexp);
      chk("R3 vector root_ptr", root_ptr, VECS[i].rootexp);
      chk("R2 vector trans_en", {63'h0, trans_en}, {63'h0, VECS[i].teexp});
      @(negedge clk);
    end

    // R4 flush window, keeping translation on
    wr(A_GCMD, 64'h8800_0000);
    count_ones(A_GSTS, 27, LAT + 3, ones);
    chk("R4 flush busy cycles", 64'(ones), 64'(LAT));
    chk("R4 te kept", {63'h0, trans_en}, 64'h1);

    // R5 context invalidation with global scope
    c0 = n_ctx;
    wr(A_CCMD, 64'hA000_0000_0000_0000);
    ones = 0;
    for (int k = 0; k < LAT + 2; k++) begin
      rd(A_CCMD, v);
      if (v[63]) ones++;
      chk("R5 pulse timing", {63'h0, ctx_inv_pulse}, {63'h0, (k == LAT - 1)});
      @(negedge clk);
    end
    chk("R5 request cycles", 64'(ones), 64'(LAT));
    chk("R5 one pulse", 64'(n_ctx - c0), 64'h1);
    chk("R5 global scope", {63'h0, last_glb}, 64'h1);

    // R6 IOTLB at advertised offset, domain masked to 256
    i0 = n_iot;
    wr(A_IOT, 64'hA003_0123_0000_0000);
    count_ones(A_IOT, 63, LAT + 2, ones);
    chk("R6 request cycles", 64'(ones), 64'(LAT));
    chk("R6 one pulse", 64'(n_iot - i0), 64'h1);
    chk("R6 granularity", 64'(last_gran), 64'h2);
    chk("R6 domain masked", 64'(last_did), 64'h23);
    chk("R6 drains", {62'h0, last_drd, last_dwr}, 64'h3);
    rd(A_IOT, v);
    chk("R6 readback", v, 64'h2003_0123_0000_0000);
    @(negedge clk);

    // R7 queued context request, written one cycle after the first
    c0 = n_ctx;
    wr(A_CCMD, 64'h8000_0000_0000_0000);
    wr(A_CCMD, 64'h8000_0000_0000_0000);
    count_ones(A_CCMD, 63, 2 * LAT + 3, ones);
    chk("R7 queued pending cycles", 64'(ones), 64'(2 * LAT - 1));
    chk("R7 queued pulses", 64'(n_ctx - c0), 64'h2);
    chk("R7 local scope", {63'h0, last_glb}, 64'h0);

    // R7 second IOTLB request in the completion cycle of the first
    i0 = n_iot;
    wr(A_IOT, 64'h9000_0000_0000_0000);
    repeat (LAT - 1) @(negedge clk);
    wr(A_IOT, 64'hB000_0005_0000_0000);
    count_ones(A_IOT, 63, LAT + 2, ones);
    chk("R7 back-to-back window", 64'(ones), 64'(LAT));
    chk("R7 back-to-back pulses", 64'(n_iot - i0), 64'h2);
    chk("R7 second gran", 64'(last_gran), 64'h3);
    chk("R7 second domain", 64'(last_did), 64'h5);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule